// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Serial Register Front End

This block sits between a byte-wide host bus and a two-channel serial controller. Each channel owns sixteen write registers and sixteen read registers. The host reaches them through two bus addresses per channel: one for control and one for data. A per-channel register pointer selects which register the next control access touches. The pointer is loaded by writing register 0, and a command field in that write can lift the pointer into the upper eight registers. After a single access to the selected register the pointer falls back to 0, so software always writes the pointer and then the value. Data accesses go straight to the transmit and receive byte paths.

The block also decodes the line configuration that the bit-serial engine needs. It derives the character length, the parity settings and the stop-bit count. It turns the sixteen-bit time constant and the clock-mode field into an effective divisor of the input clock. Writing a reset code into register 9 returns one channel, the other channel or both to their reset values.

Top module: `dual_serial_regif`

## Requirements
- R1: busAddr bit 0 chooses control (0) or data (1), and busAddr bit 1 chooses channel 0 or channel 1. Every access moves one byte, and an access to one channel leaves the other channel's state unchanged.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. When data bits 5:3 equal 001, 8 is added to the pointer, so it points to registers 8 to 15.
- R3: After a control write to a non-zero register, the pointer returns to 0. Every control read returns the selected read register and also returns the pointer to 0.
- R4: Values written to write registers 12 and 13 read back at read registers 12 and 13. Read registers other than 0, 1, 12 and 13 read as 0.
- R5: A write to register 9 with bits 7:6 = 01 resets channel 0, with 10 resets channel 1, and with 11 resets both. No register is written by such a command. The pointer of every channel that is reset returns to 0.
- R6: After reset, read register 0 reads 0x44 (bit 2 transmit empty, bit 6 underrun) and read register 1 reads 0x07 (bit 0 all sent). Write register 4 is 0x04, 9 is 0xC0, 11 is 0x08, 14 is 0x30 and 15 is 0xF8. All other registers are 0.
- R7: A data write sets read register 0 bit 2 and read register 1 bit 0. Only when write register 5 bit 3 is 1 is the byte presented on txByte, with a one-cycle txStrobe pulse in the cycle after the write.
- R8: rxReady is 1 when write register 3 bit 0 is 1 and read register 0 bit 0 is 0. A push while rxReady is 1 stores the byte and sets read register 0 bit 0. A push while rxReady is 0 is dropped, and the stored byte is kept.
- R9: A data read returns the stored receive byte in the same cycle as busRd. At the clock edge it clears read register 0 bit 0.
- R10: baudDiv equals 2 x (time constant + 2) x M. The time constant is write register 13 (high byte) joined to write register 12 (low byte). M is 1, 16, 32 or 64 for write register 4 bits 7:6 = 00, 01, 10 or 11.
- R11: charLen is 5, 7, 6 or 8 for write register 5 bits 6:5 = 00, 01, 10 or 11. parityEn is write register 4 bit 0. parityEven is write register 4 bit 1. twoStop is 1 when write register 4 bits 3:2 equal 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busAddr | input | 2 | Bit 0 control/data, bit 1 channel |
| busWdata | input | 8 | Host write byte |
| busRdata | output | 8 | Host read byte, valid while busRd is high |
| rxPush | input | 2 | Received-byte offer per channel |
| rxByte | input | 16 | Received bytes, channel 0 in bits 7:0 |
| rxReady | output | 2 | Channel can accept a received byte |
| txStrobe | output | 2 | One-cycle transmit byte pulse per channel |
| txByte | output | 16 | Transmit bytes, channel 0 in bits 7:0 |
| baudDiv | output | 2*DIV_W | Effective input-clock divisor per channel |
| charLen | output | 8 | Character length per channel, 4 bits each |
| parityEn | output | 2 | Parity enabled per channel |
| parityEven | output | 2 | Even parity selected per channel |
| twoStop | output | 2 | Two stop bits per channel |

## Verification
A pointer that does not return to 0 shows up on the very next control read: busRdata returns some other register instead of the status byte 0x44. A wrong pointer after a point-high write shows up as a register 12 or 13 value read back from the wrong place. A write file that is not restored by a reset command shows on baudDiv, charLen and the parity outputs one cycle after the command. Receive-flag errors show at once on rxReady and on the bit 0 of the status read.

// File: rtl/regif_pkg.sv
package regif_pkg;
  localparam int NCH    = 2;
  localparam int REGS   = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(REGS);

  typedef logic [BYTE_W-1:0] byte_t;

  // strobes from control to datapath, all valid in the access cycle
  typedef struct packed {
    logic [NCH-1:0] ctlWr;    // register write (pointer non-zero, not a reset command)
    logic [NCH-1:0] ctlRd;    // control read
    logic [NCH-1:0] datWr;    // transmit data write
    logic [NCH-1:0] datRd;    // receive data read
    logic [NCH-1:0] chanRst;  // channel reset command
    logic [IDX_W-1:0] regIdx; // selected register of the accessed channel
    byte_t wbyte;
  } regStb_t;

  localparam logic [IDX_W-1:0] IDX_RST = IDX_W'(9);

  function automatic byte_t wrResetVal(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(4):  return 8'h04;
      IDX_W'(9):  return 8'hC0;
      IDX_W'(11): return 8'h08;
      IDX_W'(14): return 8'h30;
      IDX_W'(15): return 8'hF8;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/regif_ctrl.sv
module regif_ctrl
  import regif_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [1:0]       busAddr,
  input  byte_t            busWdata,
  output regStb_t          stb
);
  logic [NCH-1:0][IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] curPtr, loadPtr;
  logic [NCH-1:0]   chSel;
  logic isData, ctlWrAny, ctlRdAny, isRstCmd;

  always_comb begin
    isData   = busAddr[0];
    chSel    = NCH'(1) << busAddr[1];
    curPtr   = ptrQ[busAddr[1]];
    ctlWrAny = busWr && !isData;
    ctlRdAny = busRd && !busWr && !isData;
    isRstCmd = ctlWrAny && (curPtr == IDX_RST) && (busWdata[7:6] != 2'b00);
    loadPtr  = {busWdata[5:3] == 3'b001, busWdata[2:0]};

    stb         = '0;
    stb.regIdx  = curPtr;
    stb.wbyte   = busWdata;
    stb.ctlWr   = (ctlWrAny && curPtr != '0 && !isRstCmd) ? chSel : '0;
    stb.ctlRd   = ctlRdAny ? chSel : '0;
    stb.datWr   = (busWr && isData) ? chSel : '0;
    stb.datRd   = (busRd && !busWr && isData) ? chSel : '0;
    stb.chanRst = isRstCmd ? {busWdata[7], busWdata[6]} : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (stb.chanRst[c] || stb.ctlRd[c])
          ptrQ[c] <= '0;
        else if (ctlWrAny && chSel[c])
          ptrQ[c] <= (curPtr == '0) ? loadPtr : '0;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gen_chk
    // R3: a control read leaves the pointer at 0
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (busRd && !busWr && !busAddr[0] && busAddr[1] == c) |=> ptrQ[c] == '0);
    // R3: a write to a non-zero register returns the pointer to 0
    p_ptr_return_r3: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && !busAddr[0] && busAddr[1] == c && ptrQ[c] != '0) |=> ptrQ[c] == '0);
    // R2: the point-high command lifts the pointer by 8
    p_point_high_r2: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && !busAddr[0] && busAddr[1] == c && ptrQ[c] == '0 && busWdata[5:3] == 3'b001)
      |=> ptrQ[c] == {1'b1, $past(busWdata[2:0])});
  end
endmodule

// File: rtl/regif_dpath.sv
module regif_dpath
  import regif_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStb_t               stb,
  input  logic [NCH-1:0]        rxPush,
  input  logic [NCH*BYTE_W-1:0] rxByte,
  output logic [NCH-1:0]        rxReady,
  output logic [NCH-1:0]        txStrobe,
  output logic [NCH*BYTE_W-1:0] txByte,
  output byte_t                 busRdata,
  output logic [NCH*DIV_W-1:0]  baudDiv,
  output logic [NCH*4-1:0]      charLen,
  output logic [NCH-1:0]        parityEn,
  output logic [NCH-1:0]        parityEven,
  output logic [NCH-1:0]        twoStop
);
  localparam int TC_W = 2 * BYTE_W;

  logic [NCH-1:0][BYTE_W-1:0] chRd;

  for (genvar c = 0; c < NCH; c++) begin : gen_ch
    byte_t wReg [REGS];
    byte_t rxQ, txD, rdLoc;
    logic  rxAvail, txEmpty, allSent, txQ;
    logic [TC_W:0] tcBase;
    logic [2:0] shamt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < REGS; i++) wReg[i] <= wrResetVal(IDX_W'(i));
        rxAvail <= 1'b0; txEmpty <= 1'b1; allSent <= 1'b1; txQ <= 1'b0;
      end else if (stb.chanRst[c]) begin
        for (int i = 0; i < REGS; i++) wReg[i] <= wrResetVal(IDX_W'(i));
        rxAvail <= 1'b0; txEmpty <= 1'b1; allSent <= 1'b1; txQ <= 1'b0;
      end else begin
        if (stb.ctlWr[c]) wReg[stb.regIdx] <= stb.wbyte;
        txQ <= stb.datWr[c] && wReg[5][3];
        if (stb.datWr[c]) begin
          txEmpty <= 1'b1;
          allSent <= 1'b1;
        end
        if (rxPush[c] && rxReady[c]) rxAvail <= 1'b1;
        else if (stb.datRd[c])       rxAvail <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxQ <= '0;
        txD <= '0;
      end else begin
        if (rxPush[c] && rxReady[c]) rxQ <= rxByte[c*BYTE_W +: BYTE_W];
        if (stb.datWr[c] && wReg[5][3]) txD <= stb.wbyte;
      end
    end

    always_comb begin
      rdLoc = '0;
      if (stb.datRd[c]) rdLoc = rxQ;
      else if (stb.ctlRd[c]) begin
        case (stb.regIdx)
          IDX_W'(0):  rdLoc = {1'b0, 1'b1, 3'b000, txEmpty, 1'b0, rxAvail};
          IDX_W'(1):  rdLoc = {5'b00000, 2'b11, allSent};
          IDX_W'(12): rdLoc = wReg[12];
          IDX_W'(13): rdLoc = wReg[13];
          default:    rdLoc = '0;
        endcase
      end
    end

    // divisor shift includes the factor 2 of the half-rate channel clock
    always_comb begin
      tcBase = {1'b0, wReg[13], wReg[12]} + (TC_W+1)'(2);
      case (wReg[4][7:6])
        2'b00:   shamt = 3'd1;
        2'b01:   shamt = 3'd5;
        2'b10:   shamt = 3'd6;
        default: shamt = 3'd7;
      endcase
    end

    assign chRd[c]       = rdLoc;
    assign rxReady[c]    = wReg[3][0] && !rxAvail;
    assign txStrobe[c]   = txQ;
    assign txByte[c*BYTE_W +: BYTE_W] = txD;
    assign baudDiv[c*DIV_W +: DIV_W]  = DIV_W'(tcBase) << shamt;
    assign charLen[c*4 +: 4] = (wReg[5][6:5] == 2'b00) ? 4'd5 :
                               (wReg[5][6:5] == 2'b01) ? 4'd7 :
                               (wReg[5][6:5] == 2'b10) ? 4'd6 : 4'd8;
    assign parityEn[c]   = wReg[4][0];
    assign parityEven[c] = wReg[4][1];
    assign twoStop[c]    = wReg[4][3:2] == 2'b11;

    // R4: a write to register 12 is visible in the next cycle
    p_mirror_r4: assert property (@(posedge clk) disable iff (!rstN)
      (stb.ctlWr[c] && stb.regIdx == IDX_W'(12)) |=> wReg[12] == $past(stb.wbyte));
    // R5: a reset command restores register 9 and clears the receive flag
    p_reset_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.chanRst[c] |=> (wReg[9] == 8'hC0 && !rxAvail));
    // R7: no transmit pulse while the transmitter is disabled
    p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.datWr[c] && !wReg[5][3]) |=> !txQ);
    // R8: a held byte is not overwritten
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (rxAvail && !stb.datRd[c]) |=> $stable(rxQ));
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NCH; c++) busRdata = busRdata | chRd[c];
  end
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import regif_pkg::*;
#(
  parameter int DIV_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [1:0]            busAddr,
  input  logic [7:0]            busWdata,
  output logic [7:0]            busRdata,
  input  logic [1:0]            rxPush,
  input  logic [15:0]           rxByte,
  output logic [1:0]            rxReady,
  output logic [1:0]            txStrobe,
  output logic [15:0]           txByte,
  output logic [2*DIV_W-1:0]    baudDiv,
  output logic [7:0]            charLen,
  output logic [1:0]            parityEn,
  output logic [1:0]            parityEven,
  output logic [1:0]            twoStop
);
  regStb_t stb;

  regif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  regif_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rxPush(rxPush), .rxByte(rxByte),
    .rxReady(rxReady), .txStrobe(txStrobe), .txByte(txByte), .busRdata(busRdata),
    .baudDiv(baudDiv), .charLen(charLen), .parityEn(parityEn),
    .parityEven(parityEven), .twoStop(twoStop)
  );
endmodule

// File: tb/dual_serial_regif_tb.sv
`timescale 1ns/1ps
module dual_serial_regif_tb;
  localparam int DIV_W = 24;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 0, busRd = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic [1:0] rxPush = 0, rxReady, txStrobe, parityEn, parityEven, twoStop;
  logic [15:0] rxByte = 0, txByte;
  logic [2*DIV_W-1:0] baudDiv;
  logic [7:0] charLen;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  dual_serial_regif #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxPush(rxPush), .rxByte(rxByte),
    .rxReady(rxReady), .txStrobe(txStrobe), .txByte(txByte), .baudDiv(baudDiv),
    .charLen(charLen), .parityEn(parityEn), .parityEven(parityEven), .twoStop(twoStop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data is compared mid-cycle
  always @(negedge clk) begin
    if (busRd) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read actual=0x%0h expected=none", busRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {24'h0, busRdata}, {24'h0, e});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    busRd = 1; busAddr = a;
    @(posedge clk); #1;
    busRd = 0;
  endtask

  task automatic setReg(input int ch, input int idx, input logic [7:0] v);
    logic [1:0] a;
    a = {ch[0], 1'b0};
    if (idx >= 8) wr(a, 8'h08 | 8'(idx & 7));
    else wr(a, 8'(idx));
    wr(a, v);
  endtask

  task automatic push(input int ch, input logic [7:0] b);
    rxPush[ch] = 1'b1; rxByte[ch*8 +: 8] = b;
    @(posedge clk); #1;
    rxPush = '0;
  endtask

  function automatic logic [31:0] expDiv(input int tc, input int mode);
    int m;
    m = (mode == 0) ? 1 : (mode == 1) ? 16 : (mode == 2) ? 32 : 64;
    return 32'(2 * (tc + 2) * m);
  endfunction

  function automatic logic [31:0] div(input int ch);
    return 32'(baudDiv[ch*DIV_W +: DIV_W]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    @(posedge clk); #1;
    // R6 reset state
    chk("R6 div ch0", div(0), expDiv(0, 0));
    chk("R6 charLen ch0", {28'h0, charLen[3:0]}, 32'd5);
    chk("R6 parity/stop", {29'h0, parityEn[0], parityEven[0], twoStop[0]}, 0);
    chk("R6 rxReady", {30'h0, rxReady}, 0);
    rd(0, 8'h44, "R6 RR0");
    wr(0, 8'h01);
    rd(0, 8'h07, "R6 RR1 via pointer R2");
    // R2 point high, R4 mirror
    setReg(0, 12, 8'h34);
    setReg(0, 13, 8'h01);
    wr(0, 8'h0C);
    rd(0, 8'h34, "R4 RR12 R2");
    rd(0, 8'h44, "R3 pointer cleared after read");
    wr(0, 8'h0D);
    rd(0, 8'h01, "R4 RR13");
    wr(0, 8'h03);
    rd(0, 8'h00, "R4 unmapped read reg");
    // R10/R11 line configuration
    setReg(0, 4, 8'hC5);
    rd(0, 8'h44, "R3 pointer cleared after write");
    chk("R10 x64", div(0), expDiv(308, 3));
    chk("R11 parityEn", {31'h0, parityEn[0]}, 1);
    chk("R11 odd", {31'h0, parityEven[0]}, 0);
    chk("R11 one stop", {31'h0, twoStop[0]}, 0);
    setReg(0, 4, 8'h4E);
    chk("R10 x16", div(0), expDiv(308, 1));
    chk("R11 twoStop", {31'h0, twoStop[0]}, 1);
    chk("R11 even", {30'h0, parityEn[0], parityEven[0]}, 32'h1);
    setReg(0, 4, 8'h80);
    chk("R10 x32", div(0), expDiv(308, 2));
    setReg(0, 5, 8'h20); chk("R11 len7", {28'h0, charLen[3:0]}, 7);
    setReg(0, 5, 8'h40); chk("R11 len6", {28'h0, charLen[3:0]}, 6);
    setReg(0, 5, 8'h68); chk("R11 len8", {28'h0, charLen[3:0]}, 8);
    // R1 channel isolation
    chk("R1 ch1 div untouched", div(1), expDiv(0, 0));
    chk("R1 ch1 len untouched", {28'h0, charLen[7:4]}, 5);
    wr(2, 8'h0C);
    rd(2, 8'h00, "R1 ch1 RR12");
    // R7 transmit
    wr(1, 8'hA5);
    chk("R7 strobe", {31'h0, txStrobe[0]}, 1);
    chk("R7 byte", {24'h0, txByte[7:0]}, 32'hA5);
    @(posedge clk); #1;
    chk("R7 single pulse", {30'h0, txStrobe}, 0);
    rd(0, 8'h44, "R7 tx empty set");
    wr(3, 8'h3C);
    chk("R7 gated when disabled", {30'h0, txStrobe}, 0);
    rd(2, 8'h44, "R7 ch1 status");
    // R8/R9 receive
    push(0, 8'h11);
    rd(0, 8'h44, "R8 push dropped when disabled");
    setReg(0, 3, 8'h01);
    chk("R8 ready", {31'h0, rxReady[0]}, 1);
    push(0, 8'h5A);
    chk("R8 busy", {31'h0, rxReady[0]}, 0);
    rd(0, 8'h45, "R8 rx available");
    push(0, 8'h77);
    rd(1, 8'h5A, "R9 data read keeps first byte R8");
    rd(0, 8'h44, "R9 avail cleared");
    chk("R9 ready again", {31'h0, rxReady[0]}, 1);
    // R5 reset commands
    setReg(1, 12, 8'h22);
    setReg(0, 9, 8'h40);
    chk("R5 ch0 div restored", div(0), expDiv(0, 0));
    chk("R5 ch0 len restored", {28'h0, charLen[3:0]}, 5);
    chk("R5 ch0 rx disabled", {31'h0, rxReady[0]}, 0);
    wr(0, 8'h0C);
    rd(0, 8'h00, "R5 ch0 RR12 cleared");
    wr(2, 8'h0C);
    rd(2, 8'h22, "R5 ch1 kept");
    wr(2, 8'h0C);
    setReg(0, 9, 8'h80);
    rd(2, 8'h44, "R5 ch1 pointer reset");
    wr(2, 8'h0C);
    rd(2, 8'h00, "R5 ch1 RR12 cleared");
    setReg(0, 12, 8'h55);
    setReg(1, 12, 8'h66);
    setReg(1, 9, 8'hC0);
    wr(0, 8'h0C);
    rd(0, 8'h00, "R5 both ch0");
    wr(2, 8'h0C);
    rd(2, 8'h00, "R5 both ch1");
    @(posedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule